// File: doc/BRIEF.md
# Burst Address Generator

This block produces the internal access address for one port of a synchronous memory. At every rising clock edge it looks at three active-low controls and picks the next address. A clear forces zero. A strobe takes the external address bus. An advance adds one to the stored address. When none of them is active, the stored address is kept. The chosen address is registered at that edge and drives the access of the cycle that edge begins, so a clear, a load or an advance costs no extra cycle.

The controls follow a fixed priority: clear wins over strobe, and strobe wins over advance. The block has no chip-enable input, so the address moves whether or not the memory port is selected. The register wraps from all ones to zero. A synchronous global reset, separate from the clear control, sets the register to zero. The address width is a parameter and defaults to 16 bits.

Top module: `burst_addr_gen`

## Requirements
- R1: While `rst` is high at a rising edge, `int_addr` is 0 after that edge, whatever the other inputs are.
- R2: With `rst` low, `clear_n` low at a rising edge makes `int_addr` 0 after that edge, whatever `load_n`, `step_n` and `ext_addr` are.
- R3: With `rst` low and `clear_n` high, `load_n` low at a rising edge copies `ext_addr` into `int_addr` at that edge, whatever `step_n` is.
- R4: With `rst` low and `clear_n` and `load_n` high, `step_n` low at a rising edge sets `int_addr` to its previous value plus one.
- R5: An advance from the all-ones address gives 0.
- R6: With `clear_n`, `load_n` and `step_n` all high, `int_addr` keeps its value across the edge and `ext_addr` has no effect.
- R7: With `load_n` held low on consecutive edges, each edge loads that cycle's `ext_addr`, so arbitrary non-sequential addresses follow each other with no gap.
- R8: `int_addr` changes only at a rising edge. The value chosen at an edge is present for the whole cycle that follows it, with no dead cycle, and is unchanged just before the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous global reset, active high |
| ext_addr | input | ADDR_W | External address, taken when the strobe is active |
| load_n | input | 1 | Address strobe, active low |
| step_n | input | 1 | Advance enable, active low |
| clear_n | input | 1 | Clear to address 0, active low |
| int_addr | output | ADDR_W | Registered internal address for the current access |

## Verification
Clear, strobe and advance can all be active at the same edge. Two further collisions matter: a strobe together with the all-ones wrap, and a global reset together with an active strobe. The bench builds a 4-bit instance and sweeps every start address, every combination of the three controls and every external value. Each result is judged against the priority rule computed in the bench: zero if cleared, otherwise the external value if strobed, otherwise the start plus one modulo 16, otherwise the start.

// File: rtl/bag_pkg.sv
package bag_pkg;

  // Operation chosen at a clock edge, listed from lowest to highest priority.
  typedef enum logic [1:0] {
    BAG_HOLD  = 2'd0,
    BAG_STEP  = 2'd1,
    BAG_LOAD  = 2'd2,
    BAG_CLEAR = 2'd3
  } bag_op_e;

endpackage

// File: rtl/bag_decode.sv
module bag_decode
  import bag_pkg::*;
(
  input  logic    clear_n,
  input  logic    load_n,
  input  logic    step_n,
  output bag_op_e op
);

  // Fixed priority: clear, then load, then step.
  always_comb begin
    if (!clear_n)     op = BAG_CLEAR;
    else if (!load_n) op = BAG_LOAD;
    else if (!step_n) op = BAG_STEP;
    else              op = BAG_HOLD;
  end

endmodule

// File: rtl/bag_next.sv
module bag_next
  import bag_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  bag_op_e           op,
  input  logic [ADDR_W-1:0] cur,
  input  logic [ADDR_W-1:0] ext,
  output logic [ADDR_W-1:0] nxt,
  output logic              wrap
);

  localparam logic [ADDR_W-1:0] TOP = {ADDR_W{1'b1}};

  // Modulo-2^ADDR_W increment.
  function automatic logic [ADDR_W-1:0] incr(input logic [ADDR_W-1:0] a);
    return a + ADDR_W'(1);
  endfunction

  always_comb begin
    unique case (op)
      BAG_CLEAR: nxt = '0;
      BAG_LOAD:  nxt = ext;
      BAG_STEP:  nxt = incr(cur);
      default:   nxt = cur;
    endcase
  end

  // Named event: an advance that rolls over the top of the range.
  assign wrap = (op == BAG_STEP) && (cur == TOP);

endmodule

// File: rtl/bag_reg.sv
module bag_reg #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] d,
  output logic [ADDR_W-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= d;
  end

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import bag_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] ext_addr,
  input  logic              load_n,
  input  logic              step_n,
  input  logic              clear_n,
  output logic [ADDR_W-1:0] int_addr
);

  bag_op_e           op;
  logic [ADDR_W-1:0] nxt_addr;
  logic              wrap_evt;

  bag_decode u_dec (
    .clear_n (clear_n),
    .load_n  (load_n),
    .step_n  (step_n),
    .op      (op)
  );

  bag_next #(.ADDR_W(ADDR_W)) u_next (
    .op   (op),
    .cur  (int_addr),
    .ext  (ext_addr),
    .nxt  (nxt_addr),
    .wrap (wrap_evt)
  );

  bag_reg #(.ADDR_W(ADDR_W)) u_reg (
    .clk (clk),
    .rst (rst),
    .d   (nxt_addr),
    .q   (int_addr)
  );

  // Global reset clears the address at the next edge.
  assert_reset_zero_R1: assert property (@(posedge clk)
    rst |=> (int_addr == '0));

  assert_clear_wins_R2: assert property (@(posedge clk) disable iff (rst)
    !clear_n |=> (int_addr == '0));

  assert_load_ext_R3: assert property (@(posedge clk) disable iff (rst)
    (clear_n && !load_n) |=> (int_addr == $past(ext_addr)));

  assert_step_plus_one_R4: assert property (@(posedge clk) disable iff (rst)
    (clear_n && load_n && !step_n) |=> (int_addr == $past(int_addr) + ADDR_W'(1)));

  assert_wrap_to_zero_R5: assert property (@(posedge clk) disable iff (rst)
    wrap_evt |=> (int_addr == '0));

  assert_hold_stable_R6: assert property (@(posedge clk) disable iff (rst)
    (clear_n && load_n && step_n) |=> $stable(int_addr));

endmodule

// File: tb/tb_burst_addr_gen.sv
module tb_burst_addr_gen;

  localparam int W = 4;
  localparam int N = 1 << W;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] ext_addr = '0;
  logic         load_n = 1'b1;
  logic         step_n = 1'b1;
  logic         clear_n = 1'b1;
  logic [W-1:0] int_addr;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  burst_addr_gen #(.ADDR_W(W)) dut (
    .clk      (clk),
    .rst      (rst),
    .ext_addr (ext_addr),
    .load_n   (load_n),
    .step_n   (step_n),
    .clear_n  (clear_n),
    .int_addr (int_addr)
  );

  always #5 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: int_addr=%0d expected %0d", req, act, exp);
    end
  endtask

  // Drive at a falling edge, let one rising edge pass, return at the next falling edge.
  task automatic apply(input bit c, input bit l, input bit s, input int e);
    clear_n  = c;
    load_n   = l;
    step_n   = s;
    ext_addr = W'(e);
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic int model(input bit c, input bit l, input bit s, input int e, input int cur);
    if (!c)      return 0;
    else if (!l) return e % N;
    else if (!s) return (cur + 1) % N;
    else         return cur;
  endfunction

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run hung, actual=running expected=finished");
      summary();
    end
  end

  initial begin
    int cur;
    // R1: reset with a load requested still yields zero.
    load_n   = 1'b0;
    ext_addr = W'(9);
    @(negedge clk);
    @(negedge clk);
    check("R1 reset", int_addr, 0);
    rst    = 1'b0;
    load_n = 1'b1;

    // Sweep: every start value, every control combination, every external value.
    for (int s = 0; s < N; s++) begin
      for (int c = 0; c < 8; c++) begin
        for (int e = 0; e < N; e++) begin
          bit cb, lb, sb;
          int exp;
          string tag;
          apply(1'b1, 1'b0, 1'b1, s);
          check("R3 load start", int_addr, s);
          cb = c[2]; lb = c[1]; sb = c[0];
          exp = model(cb, lb, sb, e, s);
          if (!cb)                 tag = "R2 clear priority";
          else if (!lb)            tag = "R3 load priority";
          else if (!sb && s == N-1) tag = "R5 wrap";
          else if (!sb)            tag = "R4 step";
          else                     tag = "R6 hold ignores ext";
          apply(cb, lb, sb, e);
          check(tag, int_addr, exp);
        end
      end
    end

    // R7: strobe held low, a scattered address every cycle.
    for (int i = 0; i < 3 * N; i++) begin
      int e;
      e = (i * 7 + 3) % N;
      apply(1'b1, 1'b0, 1'b1, e);
      check("R7 back-to-back load", int_addr, e);
    end

    // R8: new value present right after the edge, old value kept just before it.
    apply(1'b1, 1'b0, 1'b1, 5);
    clear_n = 1'b1; load_n = 1'b1; step_n = 1'b0; ext_addr = W'(12);
    #3;
    check("R8 no change before edge", int_addr, 5);
    @(posedge clk);
    #1;
    check("R8 step visible in same cycle", int_addr, 6);
    @(negedge clk);
    step_n = 1'b1; clear_n = 1'b0;
    #3;
    check("R8 no change before clear edge", int_addr, 6);
    @(posedge clk);
    #1;
    check("R8 clear with no dead cycle", int_addr, 0);
    @(negedge clk);

    // R5 via a run of advances through the top of the range.
    apply(1'b1, 1'b0, 1'b1, N - 2);
    cur = N - 2;
    for (int i = 0; i < 4; i++) begin
      apply(1'b1, 1'b1, 1'b0, 0);
      cur = (cur + 1) % N;
      check("R5 advance run", int_addr, cur);
    end

    // R6: long hold with a changing external bus.
    for (int i = 0; i < N; i++) begin
      apply(1'b1, 1'b1, 1'b1, i);
      check("R6 hold", int_addr, cur);
    end

    // R1: reset in mid-run with every control active.
    rst = 1'b1;
    apply(1'b0, 1'b0, 1'b0, 11);
    check("R1 mid-run reset", int_addr, 0);
    rst = 1'b0;
    apply(1'b1, 1'b1, 1'b1, 11);
    check("R1 reset then hold", int_addr, 0);

    done = 1'b1;
    summary();
  end

endmodule